// File: doc/BRIEF.md
# Sampling Converter Host Interface

This block is the digital, host-facing side of a 12-bit sampling converter. A host asks for a conversion in one of two ways: a rising edge on an asynchronous convert-start line, or a falling chip select while convert-start is held low. While the conversion runs, an active-low busy flag is asserted. The conversion is a fixed-latency count. At the end of the count, the 12-bit sample word offered on `sample_i` is captured into a result register.

The host reads the result over a bus that has a read-enable. The bus drives data only while chip select and read are both low. Otherwise the block reports the bus as released: output-enable is low and the data lines are zero. A mode input chooses between two layouts:

- 12-bit parallel words.
- 8-bit byte access. Here a high-byte select steers either the low byte, or the top four result bits, onto the low data lines.

The result is a polled register rather than a stream. There is no valid/ready pair and no back-pressure. A conversion always completes and overwrites the result, whether or not the host has read the previous value.

Top module: `adc_host_if`

## Requirements
- R1: After reset, `busy_n_o` is 1, `data_oe_o` is 0, and a read returns a result of zero.
- R2: A rising edge on `conv_start_i` passes through a two-flop synchroniser and an edge detector. `busy_n_o` goes low after the third rising clock edge following the input change. A falling edge on `conv_start_i` starts nothing.
- R3: `cs_n_i` going from 1 to 0 while the synchronised convert-start is 0 starts a conversion. `busy_n_o` goes low after the next rising clock edge. The same chip-select fall while convert-start is 1 starts nothing.
- R4: `busy_n_o` stays low for exactly 13 clock cycles and then returns high. At the edge where it returns high, `sample_i` is captured as the new result.
- R5: A start request of either kind that arrives while `busy_n_o` is low is ignored. It does not lengthen the conversion and does not start another one afterwards.
- R6: The result changes only at the end of a conversion. A read while busy returns the previous result.
- R7: `data_oe_o` is 1 only while `cs_n_i` and `rd_n_i` are both 0. While it is 0, `data_o` is all zeros.
- R8: With `par_mode_i` = 1, a read places result bits 11..0 on `data_o[11:0]`.
- R9: With `par_mode_i` = 0 and `hi_byte_i` = 0, a read places result bits 7..0 on `data_o[7:0]`, and `data_o[11:8]` is 0.
- R10: With `par_mode_i` = 0 and `hi_byte_i` = 1, a read places result bits 11..8 on `data_o[3:0]`, and `data_o[11:4]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start_i | input | 1 | Convert-start request; asynchronous, rising edge starts a conversion |
| cs_n_i | input | 1 | Active-low chip select; its fall starts a conversion when convert-start is low |
| rd_n_i | input | 1 | Active-low read strobe |
| par_mode_i | input | 1 | 1 = 12-bit parallel words, 0 = byte access |
| hi_byte_i | input | 1 | In byte access, 1 selects the upper result bits |
| sample_i | input | 12 | Sample word captured at the end of a conversion |
| busy_n_o | output | 1 | Active-low conversion-in-progress flag |
| data_o | output | 12 | Read data; zero while not enabled |
| data_oe_o | output | 1 | Output-enable standing in for the tri-state control |

## Verification
The hardest situation to reach from the ports is a start request that lands in the middle of a conversion. Both kinds are needed: a chip-select fall while convert-start is low, and a fresh convert-start rise that only reaches the edge detector several cycles after it was driven. The stimulus first starts a conversion. It then pulls convert-start low, drops chip select, and raises convert-start again, counting clock edges so that every request falls inside the 13 busy cycles. Afterwards the bench checks two things: busy rises on the original cycle and stays high, and the captured word is the one present at the first conversion's end.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  // Which view of the result register the read bus presents.
  typedef enum logic [1:0] {
    LANE_OFF  = 2'd0,
    LANE_FULL = 2'd1,
    LANE_LOW  = 2'd2,
    LANE_HIGH = 2'd3
  } lane_sel_e;
endpackage

// File: rtl/adc_start_detect.sv
module adc_start_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_start_i,
  input  logic cs_n_i,
  output logic start_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_d_q;
  logic                   cs_n_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      lvl_d_q  <= 1'b0;
      cs_n_d_q <= 1'b1;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], conv_start_i};
      lvl_d_q  <= sync_q[TOP];
      cs_n_d_q <= cs_n_i;
    end
  end

  // Rising edge of the synchronised convert-start, or a chip-select fall
  // while convert-start is held low.
  assign start_o = (sync_q[TOP] & ~lvl_d_q) |
                   (~sync_q[TOP] & cs_n_d_q & ~cs_n_i);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int SAMPLE_W    = 12,
  parameter int CONV_CYCLES = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                busy_o,
  output logic [SAMPLE_W-1:0] result_o
);
  localparam int              CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      cnt_q    <= '0;
      result_o <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= LOAD;
      end
    end else if (cnt_q == '0) begin
      busy_o   <= 1'b0;
      result_o <= sample_i;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_lane_mux.sv
module adc_lane_mux
  import adc_host_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int BYTE_W   = 8
) (
  input  lane_sel_e           lane_i,
  input  logic [SAMPLE_W-1:0] result_i,
  output logic [SAMPLE_W-1:0] data_o
);
  localparam int HI_W = SAMPLE_W - BYTE_W;

  always_comb begin
    data_o = '0;
    case (lane_i)
      LANE_FULL: data_o = result_i;
      LANE_LOW:  data_o[BYTE_W-1:0] = result_i[BYTE_W-1:0];
      LANE_HIGH: data_o[HI_W-1:0]   = result_i[SAMPLE_W-1:BYTE_W];
      default:   data_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_start_i,
  input  logic                cs_n_i,
  input  logic                rd_n_i,
  input  logic                par_mode_i,
  input  logic                hi_byte_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                busy_n_o,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                data_oe_o
);
  logic                start_req;
  logic                busy;
  logic [SAMPLE_W-1:0] result_q;
  lane_sel_e           lane;

  adc_start_detect #(.SYNC_STAGES(SYNC_STAGES)) start_i (
    .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start_i),
    .cs_n_i(cs_n_i), .start_o(start_req)
  );

  adc_conv_seq #(.SAMPLE_W(SAMPLE_W), .CONV_CYCLES(CONV_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_req), .sample_i(sample_i),
    .busy_o(busy), .result_o(result_q)
  );

  assign data_oe_o = ~cs_n_i & ~rd_n_i;
  assign busy_n_o  = ~busy;

  always_comb begin
    if (!data_oe_o)      lane = LANE_OFF;
    else if (par_mode_i) lane = LANE_FULL;
    else if (hi_byte_i)  lane = LANE_HIGH;
    else                 lane = LANE_LOW;
  end

  adc_lane_mux #(.SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W)) mux_i (
    .lane_i(lane), .result_i(result_q), .data_o(data_o)
  );
endmodule

// File: rtl/adc_host_if_chk.sv
module adc_host_if_chk #(
  parameter int SAMPLE_W    = 12,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                busy_n_i,
  input logic [SAMPLE_W-1:0] result_i,
  input logic                data_oe_i,
  input logic [SAMPLE_W-1:0] data_i,
  input logic                par_mode_i,
  input logic                hi_byte_i
);
  logic [15:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_run_q <= '0;
    else if (busy_n_i)          low_run_q <= '0;
    else if (low_run_q != '1)   low_run_q <= low_run_q + 16'd1;
  end

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n_i && start_i) |=> !busy_n_i);

  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n_i) |-> $past(start_i));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n_i) |-> (low_run_q == 16'(CONV_CYCLES)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_i) |-> $rose(busy_n_i));

  // R7
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe_i |-> (data_i == '0));

  // R9
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_i && !par_mode_i) |-> (data_i[SAMPLE_W-1:BYTE_W] == '0));

  // R10
  hi_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_i && !par_mode_i && hi_byte_i) |-> (data_i[BYTE_W-1:SAMPLE_W-BYTE_W] == '0));
endmodule

bind adc_host_if adc_host_if_chk #(
  .SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W), .CONV_CYCLES(CONV_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_req), .busy_n_i(busy_n_o),
  .result_i(result_q), .data_oe_i(data_oe_o), .data_i(data_o),
  .par_mode_i(par_mode_i), .hi_byte_i(hi_byte_i)
);

// File: tb/adc_host_if_tb_top.sv
module adc_host_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start_i = 1'b0;
  logic        cs_n_i = 1'b1;
  logic        rd_n_i = 1'b1;
  logic        par_mode_i = 1'b1;
  logic        hi_byte_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic        busy_n_o;
  logic [11:0] data_o;
  logic        data_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start_i), .cs_n_i(cs_n_i),
    .rd_n_i(rd_n_i), .par_mode_i(par_mode_i), .hi_byte_i(hi_byte_i),
    .sample_i(sample_i), .busy_n_o(busy_n_o), .data_o(data_o),
    .data_oe_o(data_oe_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Advance n rising edges, then settle at the following falling edge.
  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_word(logic par, logic hi, logic [11:0] exp, string req);
    par_mode_i = par; hi_byte_i = hi; cs_n_i = 1'b0; rd_n_i = 1'b0;
    #1;
    chk(req, data_oe_o, 1);
    chk(req, data_o, exp);
    cs_n_i = 1'b1; rd_n_i = 1'b1; par_mode_i = 1'b1; hi_byte_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy_n", busy_n_o, 1);
    chk("R1 oe", data_oe_o, 0);
    read_word(1'b1, 1'b0, 12'h000, "R1 result");
  endtask

  task automatic t_convst_start();
    sample_i = 12'hABC;
    conv_start_i = 1'b1;
    step(2);
    chk("R2 not before third edge", busy_n_o, 1);
    step(1);
    chk("R2 busy after third edge", busy_n_o, 0);
    for (int i = 1; i <= 12; i++) begin
      step(1);
      chk("R4 busy held", busy_n_o, 0);
    end
    step(1);
    chk("R4 busy released", busy_n_o, 1);
    read_word(1'b1, 1'b0, 12'hABC, "R8 parallel read");
  endtask

  task automatic t_cs_no_start();
    cs_n_i = 1'b0;
    step(3);
    chk("R3 cs fall with convst high", busy_n_o, 1);
    cs_n_i = 1'b1;
    step(1);
  endtask

  task automatic t_byte_and_enable();
    read_word(1'b0, 1'b0, 12'h0BC, "R9 low byte");
    read_word(1'b0, 1'b1, 12'h00A, "R10 high nibble");
    cs_n_i = 1'b0; rd_n_i = 1'b1; #1;
    chk("R7 oe rd high", data_oe_o, 0);
    chk("R7 data rd high", data_o, 0);
    cs_n_i = 1'b1; rd_n_i = 1'b0; #1;
    chk("R7 oe cs high", data_oe_o, 0);
    chk("R7 data cs high", data_o, 0);
    rd_n_i = 1'b1;
    step(1);
  endtask

  task automatic t_cs_start_read_busy();
    sample_i = 12'h5A3;
    conv_start_i = 1'b0;
    step(4);
    chk("R2 falling convst no start", busy_n_o, 1);
    cs_n_i = 1'b0; rd_n_i = 1'b0;
    step(1);
    chk("R3 cs start", busy_n_o, 0);
    chk("R6 read during busy", data_o, 12'hABC);
    for (int i = 1; i <= 12; i++) begin
      step(1);
      chk("R6 busy read keeps old", data_o, 12'hABC);
    end
    step(1);
    chk("R4 busy released", busy_n_o, 1);
    chk("R4 new result", data_o, 12'h5A3);
    cs_n_i = 1'b1; rd_n_i = 1'b1;
    step(1);
  endtask

  task automatic t_ignore_while_busy();
    sample_i = 12'h3C7;
    conv_start_i = 1'b1;
    step(3);
    chk("R2 start", busy_n_o, 0);
    conv_start_i = 1'b0;
    step(3);
    cs_n_i = 1'b0;
    step(1);
    cs_n_i = 1'b1;
    conv_start_i = 1'b1;
    step(4);
    chk("R5 busy mid", busy_n_o, 0);
    step(4);
    chk("R5 busy late", busy_n_o, 0);
    step(1);
    chk("R5 no extension", busy_n_o, 1);
    step(6);
    chk("R5 no second conversion", busy_n_o, 1);
    read_word(1'b1, 1'b0, 12'h3C7, "R5 captured word");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_convst_start();
    t_cs_no_start();
    t_byte_and_enable();
    t_cs_start_read_busy();
    t_ignore_while_busy();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule